// File: doc/BRIEF.md
# Pin-Level Asynchronous SRAM Emulator

This block stands in for an asynchronous static RAM with byte-lane control, seen from its pins. The active-low chip select, write enable, output enable and per-lane enables, the address and the incoming data are all sampled by a fast internal clock through a synchroniser. The block then decodes, lane by lane, whether that lane is being read, written or left floating. Stored data lives in one inferable memory per byte lane, of parameterised depth.

Writes are not tied to a clock edge of the host. While a write is in progress, the emulator keeps capturing the data, address and lane enables on every sample. It commits them to the array on the first sample in which chip select or write enable has returned high. Read data is driven per lane, with one output-enable bit per lane for the tristate pads. A flag warns when an outside driver is active on a lane that the emulator is currently driving.

All output behaviour trails the pins by a fixed three clock cycles: two synchroniser stages and one output register.

Top module: `sram_pin_emu`

## Requirements
- R1: While sampled chip select is high, both lane output enables are 0, whatever the other pins carry.
- R2: With chip select low, write enable high and output enable high, both lane output enables are 0.
- R3: A lane whose enable pin is high never has its output enable set.
- R4: With chip select low, write enable high and output enable low, lane i (bits 8i+7..8i of the data) drives the word stored at the sampled address. Its enable and data appear three clock cycles after the pins.
- R5: While chip select and write enable are both low, output enable is ignored and both lane output enables are 0. Only lanes whose enable is low are written; the other lane keeps its stored value.
- R6: A write is committed on the first sample where chip select or write enable is high. The committed value is the data, address and lane enables from the last sample of the write.
- R7: If chip select falls while write enable is already low, or together with it, no lane output is enabled during that cycle.
- R8: With output enable held low through a write, the lanes turn on once the write ends. They show the data at the address then presented, including a word committed in that same sample.
- R9: The clash flag is 1 three cycles after a sample in which some lane is in read mode and its external-drive sense pin is 1; otherwise it is 0.
- R10: After reset, both lane output enables and the clash flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_cs_n | input | 1 | Chip select, active low |
| pin_we_n | input | 1 | Write enable, active low |
| pin_oe_n | input | 1 | Output enable, active low |
| pin_lane_n | input | LANES | Per-lane byte enable, active low |
| pin_addr | input | ADDR_W | Word address |
| pin_dq_in | input | LANES*LANE_W | Data seen on the bus pads |
| pin_host_drv | input | LANES | Per-lane sense that an outside driver is active |
| dq_out | output | LANES*LANE_W | Read data toward the pads |
| dq_oe | output | LANES | Per-lane pad output enable |
| bus_clash | output | 1 | Outside driver active on a lane being read |

## Verification
The bench builds the emulator with a 5-bit address, giving 32 words and keeping the two-lane, 8-bit default. This brings the lowest and highest addresses into short sweeps, and lets a full write-then-read pass over every word fit in a few hundred cycles. At that depth the bench also reaches writes and reads to one address back to back, which exercises the commit-sample forwarding path. Each cycle, a behavioural model fed with the pins from three cycles earlier predicts the lane enables, read data and clash flag.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    LANE_HIZ   = 2'd0,
    LANE_READ  = 2'd1,
    LANE_WRITE = 2'd2
  } lane_mode_e;

  // Per-lane decode of the active-low control pins; write takes precedence
  // over output enable, chip select over everything.
  function automatic lane_mode_e lane_mode(input logic cs_n, input logic we_n,
                                           input logic oe_n, input logic lane_n);
    lane_mode_e m;
    if (cs_n)        m = LANE_HIZ;
    else if (!we_n)  m = lane_n ? LANE_HIZ : LANE_WRITE;
    else if (oe_n)   m = LANE_HIZ;
    else             m = lane_n ? LANE_HIZ : LANE_READ;
    return m;
  endfunction

endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_rd,
  output logic [LANES-1:0] lane_wr,
  output logic             wr_act
);

  assign wr_act = !cs_n && !we_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_mode_e mode;
    assign mode       = lane_mode(cs_n, we_n, oe_n, lane_n[g]);
    assign lane_rd[g] = (mode == LANE_READ);
    assign lane_wr[g] = (mode == LANE_WRITE);
  end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_raw;
  logic [LANE_W-1:0] fwd_data;
  logic              fwd_hit;

  // Plain write port plus registered read port: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_raw <= mem[rd_addr];
  end

  // Same-sample write/read collision is served from a bypass register.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= wr_en && (wr_addr == rd_addr);
      fwd_data <= wr_data;
    end
  end

  assign rd_data = fwd_hit ? fwd_data : rd_raw;

  // R8
  fwd_collision_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/sram_pin_emu.sv
module sram_pin_emu #(
  parameter int LANES       = 2,
  parameter int LANE_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pin_cs_n,
  input  logic                    pin_we_n,
  input  logic                    pin_oe_n,
  input  logic [LANES-1:0]        pin_lane_n,
  input  logic [ADDR_W-1:0]       pin_addr,
  input  logic [LANES*LANE_W-1:0] pin_dq_in,
  input  logic [LANES-1:0]        pin_host_drv,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe,
  output logic                    bus_clash
);

  localparam int DW    = LANES * LANE_W;
  localparam int CTL_W = 3 + LANES;
  localparam int PW    = CTL_W + ADDR_W + DW + LANES;
  localparam logic [PW-1:0] SYNC_RST = {{(PW-CTL_W){1'b0}}, {CTL_W{1'b1}}};
  localparam int A_LSB = CTL_W;
  localparam int D_LSB = A_LSB + ADDR_W;
  localparam int H_LSB = D_LSB + DW;

  logic [PW-1:0]     pins_raw;
  logic [PW-1:0]     pins_s;
  logic              cs_s, we_s, oe_s;
  logic [LANES-1:0]  lane_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DW-1:0]     data_s;
  logic [LANES-1:0]  host_s;

  assign pins_raw = {pin_host_drv, pin_dq_in, pin_addr, pin_lane_n,
                     pin_oe_n, pin_we_n, pin_cs_n};

  sram_pin_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pins_raw),
    .d_out (pins_s)
  );

  assign cs_s   = pins_s[0];
  assign we_s   = pins_s[1];
  assign oe_s   = pins_s[2];
  assign lane_s = pins_s[3 +: LANES];
  assign addr_s = pins_s[A_LSB +: ADDR_W];
  assign data_s = pins_s[D_LSB +: DW];
  assign host_s = pins_s[H_LSB +: LANES];

  logic [LANES-1:0] lane_rd;
  logic [LANES-1:0] lane_wr;
  logic             wr_act;

  sram_lane_decode #(.LANES(LANES)) u_dec (
    .cs_n    (cs_s),
    .we_n    (we_s),
    .oe_n    (oe_s),
    .lane_n  (lane_s),
    .lane_rd (lane_rd),
    .lane_wr (lane_wr),
    .wr_act  (wr_act)
  );

  // Write capture: refreshed on every sample of an active write, so the
  // values from the last sample before the terminating edge are kept.
  logic              wr_act_q;
  logic [LANES-1:0]  lat_en;
  logic [ADDR_W-1:0] lat_addr;
  logic [DW-1:0]     lat_data;
  logic              commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      lat_en   <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act) begin
        lat_en   <= lane_wr;
        lat_addr <= addr_s;
        lat_data <= data_s;
      end
    end
  end

  assign commit = wr_act_q && !wr_act;

  logic [LANES-1:0] bank_we;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    assign bank_we[g] = commit && lat_en[g];
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_we[g]),
      .wr_addr (lat_addr),
      .wr_data (lat_data[g*LANE_W +: LANE_W]),
      .rd_addr (addr_s),
      .rd_data (dq_out[g*LANE_W +: LANE_W])
    );

    // R3
    lane_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(lane_s[g]) |-> !dq_oe[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe     <= '0;
      bus_clash <= 1'b0;
    end else begin
      dq_oe     <= lane_rd;
      bus_clash <= |(lane_rd & host_s);
    end
  end

  // R1
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> (dq_oe == '0));

  // R2
  out_disable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_s && we_s && oe_s) |-> (dq_oe == '0));

  // R5
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_s && !we_s) |-> (dq_oe == '0));

  // R6
  commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (|bank_we) |-> ((cs_s || we_s) && $past(!cs_s && !we_s)));

  // R9
  clash_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_clash |-> ((|dq_oe) && $past(|host_s)));

endmodule

// File: tb/sram_pin_emu_tb.sv
`timescale 1ns/1ps
module sram_pin_emu_tb_top;

  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [1:0]  host = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        bus_clash;

  always #2.5 clk = ~clk;

  sram_pin_emu #(.LANES(2), .LANE_W(8), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_cs_n(cs_n), .pin_we_n(we_n), .pin_oe_n(oe_n),
    .pin_lane_n(lane_n), .pin_addr(addr), .pin_dq_in(dq_in),
    .pin_host_drv(host), .dq_out(dq_out), .dq_oe(dq_oe), .bus_clash(bus_clash)
  );

  typedef struct packed {
    logic cs, we, oe;
    logic [1:0] ln;
    logic [AW-1:0] a;
    logic [15:0] d;
    logic [1:0] h;
  } pin_t;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit chk_en = 0;

  pin_t hist [3];
  bit [7:0] mref [int];
  bit m_wq = 0;
  bit [1:0] m_len = 0;
  int m_la = 0;
  bit [15:0] m_ld = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Reference model: one step per cycle on the pins of three cycles ago.
  task automatic model_step(input pin_t v);
    bit wact;
    bit [1:0] eoe;
    bit ecl;
    wact = !v.cs && !v.we;
    if (m_wq && !wact)
      for (int l = 0; l < 2; l++)
        if (m_len[l]) mref[m_la*2 + l] = m_ld[l*8 +: 8];
    for (int l = 0; l < 2; l++) eoe[l] = !v.cs && v.we && !v.oe && !v.ln[l];
    ecl = |(eoe & v.h);
    if (chk_en) begin
      check(dq_oe == eoe, "lane_oe", dq_oe, eoe);
      check(bus_clash == ecl, "clash", bus_clash, ecl);
      for (int l = 0; l < 2; l++)
        if (eoe[l] && mref.exists(int'(v.a)*2 + l))
          check(dq_out[l*8 +: 8] == mref[int'(v.a)*2 + l], "rd_data",
                dq_out[l*8 +: 8], mref[int'(v.a)*2 + l]);
    end
    if (wact) begin
      m_len = ~v.ln;
      m_la  = int'(v.a);
      m_ld  = v.d;
    end
    m_wq = wact;
  endtask

  task automatic cyc(input bit c, input bit w, input bit o, input bit [1:0] ln,
                     input int a, input bit [15:0] d, input bit [1:0] h, input int n);
    for (int k = 0; k < n; k++) begin
      pin_t nv;
      @(negedge clk);
      model_step(hist[2]);
      cs_n = c; we_n = w; oe_n = o; lane_n = ln;
      addr = AW'(a); dq_in = d; host = h;
      nv = '{cs: c, we: w, oe: o, ln: ln, a: AW'(a), d: d, h: h};
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = nv;
    end
  endtask

  task automatic idle(input int n);
    cyc(1, 1, 1, 2'b11, 0, 16'h0, 2'b00, n);
  endtask

  initial begin
    #500_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) hist[i] = '{cs: 1, we: 1, oe: 1, ln: 2'b11, a: '0, d: '0, h: '0};
    idle(4);
    @(negedge clk);
    model_step(hist[2]);
    hist[2] = hist[1]; hist[1] = hist[0];
    rst = 1'b0;
    @(negedge clk);
    // R10: outputs quiet right after reset
    check(dq_oe == 2'b00, "reset_oe", dq_oe, 0);
    check(bus_clash == 1'b0, "reset_clash", bus_clash, 0);
    chk_en = 1;
    idle(3);

    // R5/R6/R8: lower-lane write with OE low; data changes, last value wins
    cur_req = "R5";
    cyc(0, 0, 0, 2'b10, 3, 16'h1111, 0, 2);
    cur_req = "R6";
    cyc(0, 0, 0, 2'b10, 3, 16'h22A5, 0, 2);
    cur_req = "R8";
    cyc(0, 1, 0, 2'b00, 3, 16'h0, 0, 5);
    // R8: write ends by WE, new address presented at once with OE low
    cyc(0, 0, 0, 2'b00, 7, 16'hC37E, 0, 2);
    cyc(0, 1, 0, 2'b00, 9, 16'h0, 0, 3);
    cyc(0, 1, 0, 2'b00, 7, 16'h0, 0, 4);
    idle(3);

    // R6: both lanes at top address, write ended by chip select
    cur_req = "R6";
    cyc(0, 0, 1, 2'b00, 31, 16'hBEEF, 0, 3);
    cyc(1, 0, 1, 2'b00, 31, 16'hBEEF, 0, 3);
    cur_req = "R4";
    cyc(0, 1, 0, 2'b00, 31, 16'h0, 0, 4);
    // R3: only upper lane enabled, then only lower
    cur_req = "R3";
    cyc(0, 1, 0, 2'b01, 31, 16'h0, 0, 4);
    cyc(0, 1, 0, 2'b10, 31, 16'h0, 0, 4);
    cyc(0, 1, 0, 2'b11, 31, 16'h0, 0, 4);

    // R5: upper-only write to address 3, lower byte must survive
    cur_req = "R5";
    cyc(0, 0, 0, 2'b01, 3, 16'h5A00, 0, 3);
    idle(2);
    cyc(0, 1, 0, 2'b00, 3, 16'h0, 0, 5);

    // R7: chip select falls with write enable already low, then together
    cur_req = "R7";
    cyc(1, 0, 0, 2'b00, 0, 16'h0102, 0, 2);
    cyc(0, 0, 0, 2'b00, 0, 16'h0102, 0, 3);
    cyc(1, 1, 0, 2'b00, 0, 16'h0, 0, 2);
    cyc(0, 0, 0, 2'b00, 1, 16'h0304, 0, 3);
    cyc(1, 1, 1, 2'b11, 0, 16'h0, 0, 2);
    cur_req = "R4";
    cyc(0, 1, 0, 2'b00, 0, 16'h0, 0, 4);
    cyc(0, 1, 0, 2'b00, 1, 16'h0, 0, 4);

    // R2: output disable
    cur_req = "R2";
    cyc(0, 1, 1, 2'b00, 1, 16'h0, 0, 5);
    // R1: deselected with all other pins in read or write positions
    cur_req = "R1";
    cyc(1, 1, 0, 2'b00, 1, 16'h0, 2'b11, 4);
    cyc(1, 0, 0, 2'b00, 2, 16'hFFFF, 0, 4);
    idle(3);

    // R9: outside driver on a lane being read, and while idle
    cur_req = "R9";
    cyc(0, 1, 0, 2'b00, 0, 16'h0, 2'b01, 4);
    cyc(0, 1, 0, 2'b01, 0, 16'h0, 2'b01, 4);
    cyc(0, 1, 0, 2'b01, 0, 16'h0, 2'b10, 4);
    cyc(0, 1, 1, 2'b00, 0, 16'h0, 2'b11, 4);
    idle(3);

    // R4: sweep every address, write then read back in changing order
    cur_req = "R4";
    for (int a = 0; a < 32; a++) begin
      cyc(0, 0, 1, 2'b00, a, 16'((a * 16'h0257) ^ 16'h9C31), 0, 2);
      cyc(0, 1, 1, 2'b00, a, 16'h0, 0, 1);
    end
    for (int a = 31; a >= 0; a--) cyc(0, 1, 0, 2'b00, a, 16'h0, 0, 1);
    for (int a = 0; a < 32; a += 3) cyc(0, 1, 0, 2'b00, a, 16'h0, 0, 2);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule